// File: doc/BRIEF.md
# BCD Calendar Clock with Per-Field Alarm Masking

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year. A single-cycle pulse input marks each period of a 32.768 kHz reference that has already been brought into the system clock domain. A prescaler divides these pulses down to one calendar step per second. Host software reads and writes every time field, every alarm field, a control byte, an alarm-control byte and a pending byte through a byte-wide register port. Reads are combinational and writes take effect at the clock edge.

The alarm compares only those fields whose own match bit is set. A separate global bit decides whether a new match may raise the alarm pending flag. The pending flag is set once, on the step where the masked comparison turns true, and is cleared by writing one to its bit. A second pending flag records every calendar step.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Register map at byte addresses: 0 control, 1 alarm control, 2 pending, 3..8 time (second, minute, hour, day, month, year), 9..14 alarm (same field order). Fields are packed BCD. Alarm registers and both control bytes read back what was written. After reset the control byte is 0 and the time is 00:00:00, day 01, month 01, year 00. Unused addresses read 0.
- R2: On a step, seconds and minutes wrap from 59 to 00 and hours from 23 to 00, each wrap carrying one into the next field.
- R3: The day wraps to 01 after the last day of the month: 31, 30 for months 04/06/09/11, and for month 02 either 29 when the two-digit year is divisible by 4 or 28 otherwise. The month wraps from 12 to 01 with a carry into the year, and the year wraps from 99 to 00.
- R4: With control bit 1 and bit 2 clear, one step occurs on every PRESCALE_DIV-th reference pulse. A write to the seconds register restarts the division, so the next step needs a full PRESCALE_DIV pulses.
- R5: Control bit 0 is the clock enable. While it is clear, no step occurs, time registers read 0 and writes to them are ignored.
- R6: Control bit 2 (hold) stops stepping and keeps the prescaler cleared. Control bit 1 (fast test) makes every reference pulse a step.
- R7: Alarm-control bits 0..5 enable matching of second, minute, hour, day, month and year. Bit 6 is the global alarm enable. A field whose bit is clear takes no part in the comparison.
- R8: The alarm pending flag is set only on a step whose new time matches all enabled fields while the time before the step did not, and only while the global enable is set. With no field enabled, no alarm ever occurs.
- R9: Pending byte bit 0 is the alarm flag and bit 1 the step flag, which is set on every step. Writing 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R10: Output irq_alarm equals the alarm pending flag and irq_tick equals the step pending flag.
- R11: A step that coincides with a write to a minute-to-year time field is applied one cycle later. A step that coincides with a seconds write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_32k | input | 1 | One-cycle pulse per reference-clock period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_alarm | output | 1 | Alarm interrupt (pending flag) |
| irq_tick | output | 1 | Step interrupt (pending flag) |

## Verification
Two same-cycle pairs are provoked in fast test mode by driving the write strobe and the reference pulse in one cycle. The first pair is a host write to a time field together with a step. The bench checks that a minute write produces the stepped seconds one cycle later, and that a seconds write swallows the step. The second pair is a write-one-to-clear on the pending byte together with an alarm step; it is judged by reading back both pending bits still set.

// File: rtl/wallclock_pkg.sv
package wallclock_pkg;

  localparam int unsigned NF     = 6;
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_DAY  = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YR   = 5;

  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_AEN   = 1;
  localparam int unsigned A_PEND  = 2;
  localparam int unsigned A_TIME0 = 3;
  localparam int unsigned A_ALM0  = A_TIME0 + NF;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_FAST = 1;
  localparam int unsigned CB_HOLD = 2;
  localparam int unsigned CTRL_W  = 3;
  localparam int unsigned AEN_W   = NF + 1;
  localparam int unsigned AEN_GLB = NF;

  typedef logic [NF-1:0][7:0] cal_t;

  // Lowest legal value of each field: also the wrap target and the reset time.
  localparam cal_t FIELD_BASE = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/wallclock_prescaler.sv
module wallclock_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic fast,
  output logic step
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    step   = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!run || restart) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (fast || cnt_q == LAST) begin
        step  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_halt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  assert_restart_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/wallclock_calendar.sv
module wallclock_calendar
  import wallclock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [NF-1:0] wr_en,
  input  logic [7:0]    wr_data,
  output cal_t          cal_q,
  output cal_t          cal_nx
);
  cal_t lim;
  cal_t cal_d;
  logic upd;
  logic carry;

  always_comb begin
    lim        = {8'h99, 8'h12, 8'h00, 8'h23, 8'h59, 8'h59};
    lim[F_DAY] = month_len(cal_q[F_MON], cal_q[F_YR]);
  end

  // Ripple the one-second increment through the fields, lowest first.
  always_comb begin
    cal_nx = cal_q;
    carry  = 1'b1;
    for (int i = 0; i < NF; i++) begin
      if (carry) begin
        if (cal_q[i] >= lim[i]) begin
          cal_nx[i] = FIELD_BASE[i];
        end else begin
          cal_nx[i] = bcd_inc(cal_q[i]);
          carry     = 1'b0;
        end
      end
    end
  end

  always_comb begin
    cal_d = adv ? cal_nx : cal_q;
    for (int i = 0; i < NF; i++) begin
      if (wr_en[i]) cal_d[i] = wr_data;
    end
    upd = adv | (|wr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cal_q <= FIELD_BASE;
    else if (upd) cal_q <= cal_d;
  end

  assert_day_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(|wr_en) && cal_q[F_SEC] == 8'h59 && cal_q[F_MIN] == 8'h59 && cal_q[F_HR] == 8'h23)
    |=> (cal_q[F_HR] == 8'h00 && cal_q[F_MIN] == 8'h00 && cal_q[F_SEC] == 8'h00));

  assert_leap_feb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(|wr_en) && cal_q[F_SEC] == 8'h59 && cal_q[F_MIN] == 8'h59 && cal_q[F_HR] == 8'h23
     && cal_q[F_DAY] == 8'h28 && cal_q[F_MON] == 8'h02 && cal_q[F_YR] == 8'h04)
    |=> (cal_q[F_DAY] == 8'h29 && cal_q[F_MON] == 8'h02));

endmodule

// File: rtl/wallclock_alarm.sv
module wallclock_alarm
  import wallclock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          glob_en,
  input  logic [NF-1:0] fld_en,
  input  cal_t          alm,
  input  cal_t          cur,
  input  cal_t          nx,
  input  logic          clr,
  output logic          pend
);
  logic match_cur, match_nx, first, set;
  logic pend_d, pend_en;

  always_comb begin
    match_cur = 1'b1;
    match_nx  = 1'b1;
    for (int i = 0; i < NF; i++) begin
      if (fld_en[i] && cur[i] != alm[i]) match_cur = 1'b0;
      if (fld_en[i] && nx[i]  != alm[i]) match_nx  = 1'b0;
    end
    first   = match_nx & ~match_cur;
    set     = adv & glob_en & first;
    pend_d  = (pend & ~clr) | set;
    pend_en = set | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_d;
  end

  assert_rise_at_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(adv) && $past(glob_en)));

  assert_no_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_en == '0) |=> !$rose(pend));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clr) |=> pend);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import wallclock_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic [AEN_W-1:0]  aen_q;
  cal_t              alm_q;
  cal_t              cal_q, cal_nx;
  logic              defer_q, defer_d;
  logic              tick_pend_q, tick_pend_d, tick_pend_en;
  logic              alm_pend;
  logic [NF-1:0]     wr_time, wr_alm;
  logic              wr_ctrl, wr_aen, wr_pend;
  logic              counting, step, want, adv, time_wr;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_aen  = bus_we && (bus_addr == ADDR_W'(A_AEN));
  assign wr_pend = bus_we && (bus_addr == ADDR_W'(A_PEND));

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign wr_time[i] = bus_we && (bus_addr == ADDR_W'(A_TIME0 + i)) && ctrl_q[CB_RUN];
    assign wr_alm[i]  = bus_we && (bus_addr == ADDR_W'(A_ALM0 + i));
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)       alm_q[i] <= 8'h00;
      else if (wr_alm[i]) alm_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    aen_q <= '0;
    else if (wr_aen) aen_q <= bus_wdata[AEN_W-1:0];
  end

  assign counting = ctrl_q[CB_RUN] & ~ctrl_q[CB_HOLD];
  assign time_wr  = |wr_time;

  wallclock_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (tick_32k),
    .run     (counting),
    .restart (wr_time[F_SEC]),
    .fast    (ctrl_q[CB_FAST]),
    .step    (step)
  );

  // A step colliding with a time write waits one cycle; a seconds write drops it.
  always_comb begin
    want    = (step | defer_q) & counting;
    adv     = want & ~time_wr;
    defer_d = want & time_wr & ~wr_time[F_SEC];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) defer_q <= 1'b0;
    else          defer_q <= defer_d;
  end

  wallclock_calendar u_cal (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .adv     (adv),
    .wr_en   (wr_time),
    .wr_data (bus_wdata),
    .cal_q   (cal_q),
    .cal_nx  (cal_nx)
  );

  wallclock_alarm u_alarm (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .adv     (adv),
    .glob_en (aen_q[AEN_GLB]),
    .fld_en  (aen_q[NF-1:0]),
    .alm     (alm_q),
    .cur     (cal_q),
    .nx      (cal_nx),
    .clr     (wr_pend & bus_wdata[0]),
    .pend    (alm_pend)
  );

  always_comb begin
    tick_pend_d  = (tick_pend_q & ~(wr_pend & bus_wdata[1])) | adv;
    tick_pend_en = adv | wr_pend;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)          tick_pend_q <= 1'b0;
    else if (tick_pend_en) tick_pend_q <= tick_pend_d;
  end

  assign irq_alarm = alm_pend;
  assign irq_tick  = tick_pend_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
    if (bus_addr == ADDR_W'(A_AEN))  bus_rdata = {{(8-AEN_W){1'b0}}, aen_q};
    if (bus_addr == ADDR_W'(A_PEND)) bus_rdata = {6'd0, tick_pend_q, alm_pend};
    for (int i = 0; i < NF; i++) begin
      if (bus_addr == ADDR_W'(A_TIME0 + i)) bus_rdata = ctrl_q[CB_RUN] ? cal_q[i] : 8'h00;
      if (bus_addr == ADDR_W'(A_ALM0 + i))  bus_rdata = alm_q[i];
    end
  end

  assert_tick_at_step_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(tick_pend_q) |-> $past(adv));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctrl_q[CB_RUN] |=> $stable(cal_q));

  assert_defer_cause_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    defer_q |-> $past(time_wr));

endmodule

// File: tb/bcd_calendar_clock_bench.sv
`timescale 1ns/1ps
module bcd_calendar_clock_bench;
  logic       clk = 1'b0;
  logic       rst_n, tick, we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_a, irq_t;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock #(.PRESCALE_DIV(4)) u_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_alarm(irq_a), .irq_tick(irq_t)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = rdata;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2, v3;
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Reset state (R1) and disabled reads (R5)
    rd(0, v); chk("R1 ctrl reset", v, 8'h00);
    rd(3, v); chk("R5 sec reads 0 when disabled", v, 8'h00);
    rd(2, v); chk("R1 pending reset", v, 8'h00);
    wr(0, 8'h01);
    rd(6, v); chk("R1 day reset", v, 8'h01);
    rd(7, v); chk("R1 month reset", v, 8'h01);
    rd(8, v); chk("R1 year reset", v, 8'h00);
    rd(15, v); chk("R1 unused address", v, 8'h00);
    wr(13, 8'h47); rd(13, v); chk("R1 alarm readback", v, 8'h47);

    // Prescaler (R4)
    wr(3, 8'h00);
    pulse(3); rd(3, v); chk("R4 no step before DIV", v, 8'h00);
    pulse(1); rd(3, v); chk("R4 step at DIV", v, 8'h01);
    rd(2, v); chk("R9 step flag set", v, 8'h02);
    chk("R10 irq_tick high", irq_t, 1);
    wr(2, 8'h02); settle(); chk("R9 step flag cleared", irq_t, 0);
    pulse(2); wr(3, 8'h40);
    pulse(3); rd(3, v); chk("R4 restart after sec write", v, 8'h40);
    pulse(1); rd(3, v); chk("R4 full period after restart", v, 8'h41);

    // Clock enable (R5)
    wr(0, 8'h00); wr(3, 8'h33); pulse(8);
    rd(3, v); chk("R5 disabled read", v, 8'h00);
    wr(0, 8'h01); rd(3, v); chk("R5 write ignored, no counting", v, 8'h41);

    // Hold and fast test bits (R6)
    wr(0, 8'h05); pulse(10); rd(3, v); chk("R6 hold stops", v, 8'h41);
    wr(0, 8'h03); pulse(1); rd(3, v); chk("R6 fast step", v, 8'h42);

    // Seconds sweep (R2)
    for (int s = 0; s < 60; s++) begin
      wr(5, 8'h05); wr(4, 8'h17); wr(3, bcd(s)); pulse(1);
      rd(3, v); chk("R2 seconds", v, bcd((s + 1) % 60));
      rd(4, v); chk("R2 seconds carry", v, (s == 59) ? 8'h18 : 8'h17);
    end
    // Minutes sweep (R2)
    for (int m = 0; m < 60; m++) begin
      wr(5, 8'h05); wr(4, bcd(m)); wr(3, 8'h59); pulse(1);
      rd(4, v); chk("R2 minutes", v, bcd((m + 1) % 60));
      rd(5, v); chk("R2 minutes carry", v, (m == 59) ? 8'h06 : 8'h05);
    end
    // Hours sweep (R2)
    for (int h = 0; h < 24; h++) begin
      wr(6, 8'h10); wr(5, bcd(h)); wr(4, 8'h59); wr(3, 8'h59); pulse(1);
      rd(5, v); chk("R2 hours", v, bcd((h + 1) % 24));
      rd(6, v); chk("R2 hours carry", v, (h == 23) ? 8'h11 : 8'h10);
    end

    // Calendar sweep over all years and months (R3)
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        if (m == 2) begin
          wr(8, bcd(y)); wr(7, 8'h02); wr(6, 8'h28);
          wr(5, 8'h23); wr(4, 8'h59); wr(3, 8'h59); pulse(1);
          rd(6, v); rd(7, v2);
          chk("R3 feb 28 leap rule", {v2, v}, (y % 4 == 0) ? 16'h0229 : 16'h0301);
        end
        wr(8, bcd(y)); wr(7, bcd(m)); wr(6, bcd(dim(m, y)));
        wr(5, 8'h23); wr(4, 8'h59); wr(3, 8'h59); pulse(1);
        rd(6, v); rd(7, v2); rd(8, v3);
        chk("R3 month end", {v3, v2, v},
            {(m == 12) ? bcd((y + 1) % 100) : bcd(y), bcd(m % 12 + 1), 8'h01});
      end
    end

    // Alarm first-match and gating (R7, R8)
    wr(2, 8'h03); wr(1, 8'h42); wr(10, 8'h05);
    wr(4, 8'h04); wr(3, 8'h58);
    pulse(1); settle(); chk("R8 no alarm before match", irq_a, 0);
    pulse(1); settle(); chk("R8 alarm on first match", irq_a, 1);
    rd(2, v); chk("R9 both pending bits", v, 8'h03);
    rd(1, v); chk("R7 alarm control readback", v, 8'h42);
    wr(2, 8'h03); pulse(1); settle(); chk("R8 no re-trigger while matching", irq_a, 0);
    wr(1, 8'h02); wr(4, 8'h04); wr(3, 8'h59);
    pulse(1); settle(); chk("R8 global enable gates", irq_a, 0);
    wr(1, 8'h40); pulse(1); settle(); chk("R8 no field enabled", irq_a, 0);

    // Masked seconds sweep (R7)
    wr(1, 8'h41); wr(10, 8'h33);
    for (int a = 0; a < 60; a++) begin
      wr(2, 8'h03); wr(9, bcd(a)); wr(3, bcd((a + 59) % 60)); pulse(1);
      settle(); chk("R7 minute ignored when masked", irq_a, 1);
    end
    wr(1, 8'h43); wr(2, 8'h03); wr(9, 8'h20); wr(3, 8'h19); pulse(1);
    settle(); chk("R7 enabled minute blocks", irq_a, 0);

    // Step colliding with minute write: deferred (R11)
    wr(4, 8'h20); wr(3, 8'h10);
    @(negedge clk); we = 1'b1; addr = 4'd4; wdata = 8'h21; tick = 1'b1;
    @(posedge clk); #1 we = 1'b0; tick = 1'b0;
    rd(3, v); chk("R11 step not applied with write", v, 8'h10);
    rd(3, v); chk("R11 deferred step applied", v, 8'h11);
    rd(4, v); chk("R11 written minute kept", v, 8'h21);

    // Step colliding with seconds write: dropped (R11)
    @(negedge clk); we = 1'b1; addr = 4'd3; wdata = 8'h20; tick = 1'b1;
    @(posedge clk); #1 we = 1'b0; tick = 1'b0;
    rd(3, v); chk("R11 seconds write wins", v, 8'h20);
    rd(3, v); chk("R11 step dropped", v, 8'h20);

    // Clear colliding with set (R9)
    wr(2, 8'h03); wr(9, 8'h31); wr(1, 8'h41); wr(3, 8'h30);
    @(negedge clk); we = 1'b1; addr = 4'd2; wdata = 8'h03; tick = 1'b1;
    @(posedge clk); #1 we = 1'b0; tick = 1'b0;
    rd(2, v); chk("R9 set wins over clear", v, 8'h03);
    chk("R10 irq_alarm follows pending", irq_a, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule